// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output-compare channel for a general-purpose timer. An external counter supplies its present value and count direction each cycle, together with an update-event pulse and a trigger edge. The channel holds a compare value, optionally behind a shadow copy. It derives a reference waveform from a 3-bit mode field and drives a registered channel output with polarity applied, plus a one-cycle match flag.

Software programs the channel through a small write port. Select 0 addresses the control word and select 1 addresses the compare value. A protection level together with the channel's I/O mode can lock the mode and shadow-enable bits.

In the two PWM modes the reference is edge driven. It moves only when the comparison outcome changes, when the mode leaves frozen, or when a trigger edge acts as a compare match. A trigger reaches the output over a normal or a fast path.

Top module: `oc_channel`

## Requirements
- R1: While reset is asserted, `ref_o`, `ch_o` and `match_o` are 0, and the mode is frozen (000), so the reference holds 0 after reset until the mode is written.
- R2: Control word (select 0) fields are: bits [2:0] mode, bit 3 shadow enable, bit 4 fast enable, bit 5 polarity. In mode 001 the reference goes to 1, in 010 it goes to 0, and in 011 it inverts, at each clock edge where `cnt_i` equals the active compare value.
- R3: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge. Mode 000 holds the reference unchanged, even on a compare match.
- R4: In PWM mode 0 (110), counting up (`cnt_down_i`=0), the reference is 1 while count < compare and 0 otherwise. Counting down, it is 0 while count > compare and 1 otherwise. PWM mode 1 (111) gives the inverse level in both directions.
- R5: In a PWM mode the reference takes its computed level on the first edge after the mode leaves frozen (000). After that, and after entry from any other mode, it changes only when the up/down comparison outcome changes.
- R6: With shadow enable clear, a compare write (select 1) is active from the next edge. With it set, the write goes to a shadow copy that becomes active on an edge where `upd_evt_i` is 1.
- R7: In a PWM mode a trigger edge acts as a compare match. It drives the reference to 1 in mode 110 and to 0 in mode 111, whatever the comparison gives. With `trig_i` sampled high on edge 1, the outputs change on edge 5 with fast enable clear and on edge 3 with it set.
- R8: Outside the PWM modes a trigger edge has no effect on the reference.
- R9: While `prot_i` = 11 and `io_mode_i` = 00, control writes leave the mode and shadow enable unchanged. Fast enable and polarity are still written.
- R10: `ch_o` equals the reference XOR the polarity bit. It is registered, so a polarity write shows on `ch_o` one edge after the write edge.
- R11: `match_o` is 1 for the cycle after an edge where `cnt_i` equals the active compare value, and 0 otherwise, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Counter value from the timer |
| cnt_down_i | input | 1 | 1 when the counter is counting down |
| upd_evt_i | input | 1 | Update-event pulse that loads the shadow compare value |
| trig_i | input | 1 | Trigger edge pulse, one cycle per edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control word, 1 = compare value |
| wr_data_i | input | DATA_W | Write data (DATA_W = max(CNT_W, 6)) |
| prot_i | input | 2 | Protection level; 11 locks mode and shadow enable |
| io_mode_i | input | 2 | Channel I/O mode; 00 = compare |
| ref_o | output | 1 | Reference waveform |
| ch_o | output | 1 | Polarity-adjusted channel output |
| match_o | output | 1 | Compare match flag |

## Verification
A stale active compare value shows at once on `match_o`: the flag appears one edge after the wrong count. In a PWM mode it also moves the transition of `ref_o`. A lost or duplicated comparison history bit makes the reference either skip a level change or move when no change is due. This shows on the edge the counter crosses the compare value, or while the channel is parked in a forced mode after a switch into PWM. A trigger pipeline tapped at the wrong stage moves the trigger-driven change of `ref_o` by whole cycles. The bench therefore samples the edges just before and just after the expected latency.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_HOLD = 3'b000,
        OCM_SET  = 3'b001,
        OCM_CLR  = 3'b010,
        OCM_TOG  = 3'b011,
        OCM_LO   = 3'b100,
        OCM_HI   = 3'b101,
        OCM_PWM0 = 3'b110,
        OCM_PWM1 = 3'b111
    } oc_mode_e;

    typedef struct packed {
        logic     pol;
        logic     fast_en;
        logic     shadow_en;
        oc_mode_e mode;
    } oc_ctrl_t;

    localparam int unsigned CTRL_W = 6;

    function automatic logic is_pwm(oc_mode_e m);
        return (m == OCM_PWM0) || (m == OCM_PWM1);
    endfunction

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
    import oc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        prot,
    input  logic [1:0]        io_mode,
    input  logic              upd_evt,
    output oc_ctrl_t          ctrl_o,
    output logic [CNT_W-1:0]  cmp_o
);

    typedef struct packed {
        oc_ctrl_t         ctrl;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } cfg_t;

    cfg_t r_d, r_q;
    logic locked;

    always_comb begin
        r_d    = r_q;
        locked = (prot == 2'b11) && (io_mode == 2'b00);
        if (wr_en && !wr_sel) begin
            if (!locked) begin
                r_d.ctrl.mode      = oc_mode_e'(wr_data[2:0]);
                r_d.ctrl.shadow_en = wr_data[3];
            end
            r_d.ctrl.fast_en = wr_data[4];
            r_d.ctrl.pol     = wr_data[5];
        end
        if (upd_evt && r_q.ctrl.shadow_en) begin
            r_d.active = r_q.shadow;
        end
        if (wr_en && wr_sel) begin
            r_d.shadow = wr_data[CNT_W-1:0];
            if (!r_q.ctrl.shadow_en) begin
                r_d.active = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_o = r_q.ctrl;
    assign cmp_o  = r_q.active;

    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && prot == 2'b11 && io_mode == 2'b00)
        |=> ($stable(r_q.ctrl.mode) && $stable(r_q.ctrl.shadow_en)));

    assert_cmp_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !r_q.ctrl.shadow_en)
        |=> (r_q.active == $past(wr_data[CNT_W-1:0])));

    assert_cmp_shadowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && r_q.ctrl.shadow_en && !upd_evt)
        |=> $stable(r_q.active));

endmodule

// File: rtl/oc_trig_pipe.sv
module oc_trig_pipe #(
    parameter int NORM_LAT = 5,
    parameter int FAST_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic fast_en_i,
    output logic fire_o
);

    localparam int DEPTH    = NORM_LAT - 1;
    localparam int TAP_NORM = NORM_LAT - 2;
    localparam int TAP_FAST = FAST_LAT - 2;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = trig_i;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_comb begin
            pipe_d[s] = pipe_q[s-1];
        end

        assert_stage_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_q[s-1] |=> pipe_q[s]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign fire_o = fast_en_i ? pipe_q[TAP_FAST] : pipe_q[TAP_NORM];

    initial begin
        assert_lat_order_R7: assert (FAST_LAT >= 2 && FAST_LAT < NORM_LAT);
    end

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  oc_ctrl_t         ctrl,
    input  logic [CNT_W-1:0] cmp,
    input  logic             fire,
    output logic             ref_o,
    output logic             ch_o,
    output logic             match_o
);

    typedef struct packed {
        logic ref_lvl;
        logic ch;
        logic match;
        logic raw;
        logic was_hold;
    } st_t;

    st_t  s_d, s_q;
    logic eq_now;
    logic raw_now;
    logic lvl_now;
    logic act_lvl;

    always_comb begin
        s_d     = s_q;
        eq_now  = (cnt == cmp);
        raw_now = down ? (cnt <= cmp) : (cnt < cmp);
        lvl_now = raw_now ^ (ctrl.mode == OCM_PWM1);
        act_lvl = (ctrl.mode == OCM_PWM0);

        s_d.match    = eq_now;
        s_d.raw      = raw_now;
        s_d.was_hold = (ctrl.mode == OCM_HOLD);

        case (ctrl.mode)
            OCM_HOLD: s_d.ref_lvl = s_q.ref_lvl;
            OCM_SET:  if (eq_now) s_d.ref_lvl = 1'b1;
            OCM_CLR:  if (eq_now) s_d.ref_lvl = 1'b0;
            OCM_TOG:  if (eq_now) s_d.ref_lvl = ~s_q.ref_lvl;
            OCM_LO:   s_d.ref_lvl = 1'b0;
            OCM_HI:   s_d.ref_lvl = 1'b1;
            OCM_PWM0, OCM_PWM1: begin
                if (fire) begin
                    s_d.ref_lvl = act_lvl;
                end else if (s_q.was_hold || (raw_now != s_q.raw)) begin
                    s_d.ref_lvl = lvl_now;
                end
            end
        endcase

        s_d.ch = s_d.ref_lvl ^ ctrl.pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_o   = s_q.ref_lvl;
    assign ch_o    = s_q.ch;
    assign match_o = s_q.match;

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == OCM_HOLD) |=> $stable(s_q.ref_lvl));

    assert_force_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == OCM_HI) |=> s_q.ref_lvl);

    assert_force_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == OCM_LO) |=> !s_q.ref_lvl);

    assert_pwm_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(ctrl.mode) && !fire && !s_q.was_hold && raw_now == s_q.raw)
        |=> $stable(s_q.ref_lvl));

    assert_trig_pwm0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == OCM_PWM0 && fire) |=> s_q.ref_lvl);

    assert_trig_pwm1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == OCM_PWM1 && fire) |=> !s_q.ref_lvl);

    assert_polarity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.ch == (s_q.ref_lvl ^ $past(ctrl.pol))));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int  CNT_W    = 16,
    parameter int  NORM_LAT = 5,
    parameter int  FAST_LAT = 3,
    localparam int DATA_W   = (CNT_W > int'(CTRL_W)) ? CNT_W : int'(CTRL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cnt_down_i,
    input  logic              upd_evt_i,
    input  logic              trig_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        prot_i,
    input  logic [1:0]        io_mode_i,
    output logic              ref_o,
    output logic              ch_o,
    output logic              match_o
);

    oc_ctrl_t         ctrl_w;
    logic [CNT_W-1:0] cmp_w;
    logic             fire_w;

    oc_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .prot    (prot_i),
        .io_mode (io_mode_i),
        .upd_evt (upd_evt_i),
        .ctrl_o  (ctrl_w),
        .cmp_o   (cmp_w)
    );

    oc_trig_pipe #(.NORM_LAT(NORM_LAT), .FAST_LAT(FAST_LAT)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .fast_en_i (ctrl_w.fast_en),
        .fire_o    (fire_w)
    );

    oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_i),
        .down    (cnt_down_i),
        .ctrl    (ctrl_w),
        .cmp     (cmp_w),
        .fire    (fire_w),
        .ref_o   (ref_o),
        .ch_o    (ch_o),
        .match_o (match_o)
    );

    assert_match_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == cmp_w) |=> match_o);

    assert_match_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != cmp_w) |=> !match_o);

endmodule

// File: tb/sim_oc_channel.sv
module sim_oc_channel;

    localparam int CNT_W  = 4;
    localparam int DATA_W = 6;
    localparam int NV     = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cnt = '0;
    logic              down = 1'b0;
    logic              upd = 1'b0;
    logic              trig = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        prot = 2'b00;
    logic [1:0]        io_mode = 2'b00;
    logic              ref_w, ch_w, match_w;

    int checks = 0;
    int errors = 0;

    oc_channel #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down),
        .upd_evt_i(upd), .trig_i(trig), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .prot_i(prot), .io_mode_i(io_mode),
        .ref_o(ref_w), .ch_o(ch_w), .match_o(match_w)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] cw(int m, bit sh, bit f, bit p);
        return {p, f, sh, m[2:0]};
    endfunction

    task automatic wr(bit sel, logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic step(int v);
        cnt = CNT_W'(v);
        tick();
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        tick();
        trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 reset ref", ref_w, 1'b0);
        chk("R1 reset ch", ch_w, 1'b0);
        chk("R1 reset match", match_w, 1'b0);
        rst_n = 1'b1;
        step(3);
        step(9);
        chk("R1 frozen after reset", ref_w, 1'b0);

        // R4 / R11 / R10: exhaustive sweep of both PWM modes, directions, compares
        for (int m = 6; m <= 7; m++) begin
            for (int d = 0; d <= 1; d++) begin
                for (int c = 0; c < NV; c++) begin
                    wr(1'b0, cw(0, 0, 0, 0));
                    wr(1'b1, DATA_W'(c));
                    down = d[0];
                    wr(1'b0, cw(m, 0, 0, 0));
                    for (int v = 0; v < NV; v++) begin
                        logic e;
                        step(v);
                        e = (d == 0) ? (v < c) : (v <= c);
                        if (m == 7) e = ~e;
                        chk("R4 pwm level", ref_w, e);
                        chk("R10 ch equals ref", ch_w, e);
                        chk("R11 match", match_w, (v == c));
                    end
                end
            end
        end
        down = 1'b0;

        // R2: set, clear, toggle on match
        wr(1'b0, cw(0, 0, 0, 0));
        wr(1'b1, DATA_W'(7));
        step(3);
        wr(1'b0, cw(4, 0, 0, 0));
        tick();
        chk("R3 force low", ref_w, 1'b0);
        wr(1'b0, cw(1, 0, 0, 0));
        step(6);  chk("R2 set no match", ref_w, 1'b0);
        step(7);  chk("R2 set on match", ref_w, 1'b1);
        step(8);  chk("R2 set holds", ref_w, 1'b1);
        wr(1'b0, cw(2, 0, 0, 0));
        step(7);  chk("R2 clear on match", ref_w, 1'b0);
        step(8);
        wr(1'b0, cw(3, 0, 0, 0));
        step(6);  chk("R2 toggle no match", ref_w, 1'b0);
        step(7);  chk("R2 toggle first", ref_w, 1'b1);
        step(8);  chk("R2 toggle holds", ref_w, 1'b1);
        step(7);  chk("R2 toggle second", ref_w, 1'b0);
        step(8);

        // R3 forced and frozen, R11 match in those modes
        wr(1'b0, cw(5, 0, 0, 0));
        tick();   chk("R3 force high", ref_w, 1'b1);
        wr(1'b0, cw(0, 0, 0, 0));
        step(7);  chk("R3 frozen ignores match", ref_w, 1'b1);
        chk("R11 match while frozen", match_w, 1'b1);
        wr(1'b0, cw(4, 0, 0, 0));
        tick();   chk("R3 force low again", ref_w, 1'b0);
        chk("R11 match while forced", match_w, 1'b1);
        wr(1'b0, cw(0, 0, 0, 0));
        step(2);
        step(7);  chk("R3 frozen holds low", ref_w, 1'b0);

        // R10 polarity
        wr(1'b0, cw(0, 0, 0, 1));
        chk("R10 ch not yet", ch_w, 1'b0);
        tick();   chk("R10 ch inverted", ch_w, 1'b1);
        chk("R10 ref unchanged", ref_w, 1'b0);
        wr(1'b0, cw(0, 0, 0, 0));
        tick();   chk("R10 ch restored", ch_w, 1'b0);

        // R5 entry from forced mode: edge-only
        wr(1'b1, DATA_W'(5));
        step(10);
        wr(1'b0, cw(5, 0, 0, 0));
        tick();
        wr(1'b0, cw(6, 0, 0, 0));
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 level kept after forced", ref_w, 1'b1);
        end
        step(2);  chk("R5 comparison rise", ref_w, 1'b1);
        step(12); chk("R5 comparison fall", ref_w, 1'b0);

        // R7 normal latency trigger
        pulse_trig();
        chk("R7 norm edge1", ref_w, 1'b0);
        for (int k = 2; k <= 4; k++) begin
            tick();
            chk("R7 norm before latency", ref_w, 1'b0);
        end
        tick();   chk("R7 norm at edge5", ref_w, 1'b1);
        chk("R7 norm ch", ch_w, 1'b1);
        tick();   chk("R7 level held", ref_w, 1'b1);
        step(2);
        step(12); chk("R7 rearm", ref_w, 1'b0);

        // R7 fast latency trigger
        wr(1'b0, cw(6, 0, 1, 0));
        pulse_trig();
        chk("R7 fast edge1", ref_w, 1'b0);
        tick();   chk("R7 fast edge2", ref_w, 1'b0);
        tick();   chk("R7 fast at edge3", ref_w, 1'b1);
        repeat (3) tick();
        wr(1'b0, cw(7, 0, 1, 0));
        tick();   chk("R7 pwm1 before trig", ref_w, 1'b1);
        pulse_trig();
        tick();   chk("R7 pwm1 edge2", ref_w, 1'b1);
        tick();   chk("R7 pwm1 forced low", ref_w, 1'b0);
        repeat (3) tick();

        // R8 trigger outside PWM
        wr(1'b0, cw(1, 0, 0, 0));
        tick();   chk("R8 set mode start", ref_w, 1'b0);
        pulse_trig();
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R8 trig ignored", ref_w, 1'b0);
        end
        wr(1'b0, cw(1, 0, 1, 0));
        pulse_trig();
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R8 fast trig ignored", ref_w, 1'b0);
        end

        // R6 shadow
        wr(1'b0, cw(0, 1, 0, 0));
        wr(1'b1, DATA_W'(9));
        step(9);  chk("R6 shadow not active", match_w, 1'b0);
        step(5);  chk("R6 old compare active", match_w, 1'b1);
        upd = 1'b1; step(0); upd = 1'b0;
        step(9);  chk("R6 loaded on update", match_w, 1'b1);
        step(5);  chk("R6 old compare gone", match_w, 1'b0);
        wr(1'b0, cw(0, 0, 0, 0));
        wr(1'b1, DATA_W'(2));
        step(2);  chk("R6 direct write", match_w, 1'b1);

        // R9 lock
        wr(1'b0, cw(4, 0, 0, 0));
        tick();   chk("R9 start low", ref_w, 1'b0);
        prot = 2'b11; io_mode = 2'b00;
        wr(1'b0, cw(5, 0, 0, 0));
        tick();   chk("R9 mode locked", ref_w, 1'b0);
        tick();   chk("R9 mode still locked", ref_w, 1'b0);
        wr(1'b0, cw(5, 0, 0, 1));
        tick();   chk("R9 polarity writable", ch_w, 1'b1);
        chk("R9 ref locked", ref_w, 1'b0);
        io_mode = 2'b01;
        wr(1'b0, cw(5, 0, 0, 0));
        tick();   chk("R9 unlocked by io mode", ref_w, 1'b1);
        chk("R9 ch after unlock", ch_w, 1'b1);
        prot = 2'b00; io_mode = 2'b00;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule